// File: doc/BRIEF.md
# Slot-Multiplexed Async Bus Transceiver

This block is a slave node on a two-line asynchronous bus. Once per frame the master broadcasts a long packet on the downstream line. Every node receives the whole packet but keeps only a window of `SLOT_BYTES` bytes. The window starts at a byte index that is set on a configuration input. On the shared upstream line the node sends its own reply bytes only while its window passes. Because of this, the packet that returns to the master is a seamless chain of the windows of all the nodes.

The node has no transmit clock of its own. Each reply byte starts on the same bit boundary as the downstream byte being received, within a few clocks. The upstream output enable is taken and released only while the downstream line is in a stop bit or idle, and the upstream line idles high. The result is that a handover between two neighbouring nodes leaves no gap longer than a few clocks and causes no collision. A frame-start pulse restarts the byte count. An idle timeout closes the packet, so a lost start bit cannot leave the node driving the line.

One bit lasts `BIT_TICKS` ticks, and a tick is `CLK_DIV` clocks. For 5 Mbit/s with 16 ticks per bit, the clock runs at 80·CLK_DIV MHz.

Top module: `sabus_slot_node`

## Requirements
- R1: After reset, `miso_o` is 1, `miso_oe_o` is 0, `slot_rx_done_o` is 0 and `rx_slot_o` is all zero.
- R2: Downstream bytes are received as 1 start bit (0), 8 data bits sent LSB first, and 1 stop bit (1). Each bit is sampled at the middle of its `BIT_TICKS` tick window. Slot byte j appears on `rx_slot_o[8j+7:8j]`.
- R3: The bytes of a packet are numbered from 0, counting from the last frame start. Only bytes `slot_base_i` to `slot_base_i+SLOT_BYTES-1` are stored. Other bytes leave `rx_slot_o` unchanged.
- R4: `slot_rx_done_o` is a one-cycle pulse. It fires once per packet, after the stop bit of the last slot byte.
- R5: `miso_oe_o` is 1 during every bit of each slot byte and 0 during the other bytes. It changes only while the downstream line is idle or in a stop bit.
- R6: During slot byte k, `miso_o` carries a start bit of 0, then `tx_slot_i[8k+7:8k]` LSB first, then a stop bit of 1. Each of these bits begins no more than 4 clocks after the matching downstream bit begins.
- R7: Whenever `miso_oe_o` is 0, `miso_o` is 1.
- R8: A low pulse on `mosi_i` that is shorter than half a bit is not counted as a byte.
- R9: `frame_start_i` resets the byte count to 0. If no byte starts for `TIMEOUT_TICKS` ticks, the packet closes: until the next frame start, bytes are ignored and `miso_oe_o` stays 0.
- R10: When `slot_base_i` is 0, `miso_oe_o` rises on the cycle after `frame_start_i`, before any byte arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start_i | input | 1 | One-cycle pulse that opens a new packet |
| slot_base_i | input | CNT_W | Index of the first byte of this node's window |
| tx_slot_i | input | 8*SLOT_BYTES | Reply bytes; byte k is at [8k+7:8k] |
| mosi_i | input | 1 | Downstream serial line |
| miso_o | output | 1 | Upstream serial data |
| miso_oe_o | output | 1 | Upstream driver enable |
| rx_slot_o | output | 8*SLOT_BYTES | Bytes captured from this node's window |
| slot_rx_done_o | output | 1 | Pulse after the last window byte |

## Verification
Two events can fall in the same cycle: the stop-bit sample of the last byte before the window, and the switch of the output enable for the first window byte. The same holds at the end of the window, where the stop sample of the last slot byte meets the release of the enable. The bench sends packets back to back with no idle gap, so the next start edge follows right after these switches. It then checks that the enable is stable across the data bits of every byte, and that the reply bits line up with the downstream bits. A timeout and a restart in the middle of a packet are also provoked, and the byte count is judged from which bytes land in the captured window.

// File: rtl/sabus_pkg.sv
package sabus_pkg;
  typedef enum logic {LINE_IDLE, LINE_BUSY} line_state_e;

  // true when byte number idx lies inside the window that starts at base
  function automatic logic in_window(input logic [15:0] idx, input logic [15:0] base,
                                     input int unsigned nbytes);
    return (idx >= base) && (32'(idx - base) < nbytes);
  endfunction

  // level sent on the wire for bit slot bidx (0 start, 1..8 data LSB first, 9 stop)
  function automatic logic wire_level(input logic [3:0] bidx, input logic [7:0] data);
    if (bidx == 4'd0) return 1'b0;
    if (bidx <= 4'd8) return data[3'(bidx - 4'd1)];
    return 1'b1;
  endfunction
endpackage

// File: rtl/sabus_tick.sv
module sabus_tick #(
  parameter int unsigned DIV = 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned W = $clog2(DIV + 1);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_q == W'(DIV - 1)) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == W'(DIV - 1));
endmodule

// File: rtl/sabus_rx_engine.sv
module sabus_rx_engine
  import sabus_pkg::*;
#(
  parameter int unsigned BIT_TICKS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       line_i,
  input  logic       abort_i,
  output logic       busy_o,
  output logic [3:0] bidx_o,
  output logic       byte_ok_o,
  output logic [7:0] byte_o
);
  localparam int unsigned TW  = $clog2(BIT_TICKS);
  localparam int unsigned MID = BIT_TICKS / 2 - 1;

  line_state_e   st_q;
  logic [TW-1:0] tcnt_q;
  logic [3:0]    bidx_q;
  logic [7:0]    sh_q;
  logic          mid_w;

  assign mid_w = (st_q == LINE_BUSY) && tick_i && (tcnt_q == TW'(MID));

  always_ff @(posedge clk) begin
    if (!rst_n || abort_i) begin
      st_q   <= LINE_IDLE;
      tcnt_q <= '0;
      bidx_q <= '0;
      if (!rst_n) sh_q <= '0;
    end else if (tick_i) begin
      if (st_q == LINE_IDLE) begin
        if (!line_i) begin
          st_q   <= LINE_BUSY;
          tcnt_q <= '0;
          bidx_q <= '0;
        end
      end else begin
        if (tcnt_q == TW'(BIT_TICKS - 1)) begin
          tcnt_q <= '0;
          bidx_q <= bidx_q + 4'd1;
        end else begin
          tcnt_q <= tcnt_q + 1'b1;
        end
        if (mid_w) begin
          if (bidx_q == 4'd0 && line_i) st_q <= LINE_IDLE;   // glitch, not a start bit
          else if (bidx_q >= 4'd1 && bidx_q <= 4'd8) sh_q <= {line_i, sh_q[7:1]};
          else if (bidx_q == 4'd9) st_q <= LINE_IDLE;
        end
      end
    end
  end

  assign busy_o    = (st_q == LINE_BUSY);
  assign bidx_o    = bidx_q;
  assign byte_ok_o = mid_w && (bidx_q == 4'd9) && line_i;
  assign byte_o    = sh_q;

  // R2: the bit slot counter never runs past the stop bit
  assert_bit_index_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (bidx_o <= 4'd9));
endmodule

// File: rtl/sabus_slot_ctrl.sv
module sabus_slot_ctrl
  import sabus_pkg::*;
#(
  parameter int unsigned CNT_W         = 8,
  parameter int unsigned SLOT_BYTES    = 12,
  parameter int unsigned TIMEOUT_TICKS = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick_i,
  input  logic                    frame_start_i,
  input  logic                    busy_i,
  input  logic                    byte_ok_i,
  input  logic [7:0]              byte_i,
  input  logic [CNT_W-1:0]        base_i,
  output logic                    oe_o,
  output logic [$clog2(SLOT_BYTES)-1:0] tx_sel_o,
  output logic [8*SLOT_BYTES-1:0] slot_o,
  output logic                    done_o
);
  localparam int unsigned PW = $clog2(SLOT_BYTES);
  localparam int unsigned IW = $clog2(TIMEOUT_TICKS + 1);

  logic [CNT_W-1:0]        cnt_q;
  logic                    open_q, oe_q, done_q;
  logic [IW-1:0]           idle_q;
  logic [8*SLOT_BYTES-1:0] slot_q;
  logic                    in_now_w, in_next_w;
  logic [CNT_W-1:0]        diff_w;

  assign diff_w    = cnt_q - base_i;
  assign in_now_w  = in_window(16'(cnt_q), 16'(base_i), SLOT_BYTES);
  assign in_next_w = in_window(16'(cnt_q) + 16'd1, 16'(base_i), SLOT_BYTES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0; open_q <= 1'b0; oe_q <= 1'b0; done_q <= 1'b0;
      idle_q <= '0; slot_q <= '0;
    end else if (frame_start_i) begin
      cnt_q  <= '0;
      open_q <= 1'b1;
      idle_q <= '0;
      done_q <= 1'b0;
      oe_q   <= in_window(16'd0, 16'(base_i), SLOT_BYTES);
    end else begin
      done_q <= 1'b0;
      if (open_q && byte_ok_i) begin
        if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
        idle_q <= '0;
        oe_q   <= in_next_w;
        for (int j = 0; j < SLOT_BYTES; j++)
          if (in_now_w && diff_w == CNT_W'(j)) slot_q[8*j +: 8] <= byte_i;
        if (in_now_w && diff_w == CNT_W'(SLOT_BYTES - 1)) done_q <= 1'b1;
      end else if (busy_i) begin
        idle_q <= '0;
      end else if (open_q && tick_i) begin
        if (idle_q == IW'(TIMEOUT_TICKS - 1)) begin
          open_q <= 1'b0;
          oe_q   <= 1'b0;
        end else begin
          idle_q <= idle_q + 1'b1;
        end
      end
    end
  end

  assign oe_o     = oe_q;
  assign tx_sel_o = in_now_w ? diff_w[PW-1:0] : '0;
  assign slot_o   = slot_q;
  assign done_o   = done_q;

  // R4: completion is a single-cycle pulse
  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R3: the byte index only steps by one or restarts at zero
  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + 1'b1 || cnt_q == '0));
  // R9: a closed packet takes no bytes into the window
  assert_closed_no_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!open_q) && $past(!frame_start_i)) |-> $stable(slot_q));
endmodule

// File: rtl/sabus_slot_node.sv
module sabus_slot_node
  import sabus_pkg::*;
#(
  parameter int unsigned CLK_DIV       = 1,
  parameter int unsigned BIT_TICKS     = 16,
  parameter int unsigned SLOT_BYTES    = 12,
  parameter int unsigned CNT_W         = 8,
  parameter int unsigned TIMEOUT_TICKS = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frame_start_i,
  input  logic [CNT_W-1:0]        slot_base_i,
  input  logic [8*SLOT_BYTES-1:0] tx_slot_i,
  input  logic                    mosi_i,
  output logic                    miso_o,
  output logic                    miso_oe_o,
  output logic [8*SLOT_BYTES-1:0] rx_slot_o,
  output logic                    slot_rx_done_o
);
  localparam int unsigned PW = $clog2(SLOT_BYTES);

  logic       tick_w, busy_w, byte_ok_w;
  logic [3:0] bidx_w;
  logic [7:0] rx_byte_w;
  logic [1:0] sync_q;
  logic       miso_q;
  logic [PW-1:0] tx_sel_w;
  logic [7:0] tx_bytes_w [SLOT_BYTES];

  for (genvar g = 0; g < SLOT_BYTES; g++) begin : g_txb
    assign tx_bytes_w[g] = tx_slot_i[8*g +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= 2'b11;
    else sync_q <= {sync_q[0], mosi_i};
  end

  sabus_tick #(.DIV(CLK_DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick_o(tick_w));

  sabus_rx_engine #(.BIT_TICKS(BIT_TICKS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_w), .line_i(sync_q[1]),
    .abort_i(frame_start_i), .busy_o(busy_w), .bidx_o(bidx_w),
    .byte_ok_o(byte_ok_w), .byte_o(rx_byte_w));

  sabus_slot_ctrl #(.CNT_W(CNT_W), .SLOT_BYTES(SLOT_BYTES),
                    .TIMEOUT_TICKS(TIMEOUT_TICKS)) u_slot (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_w), .frame_start_i(frame_start_i),
    .busy_i(busy_w), .byte_ok_i(byte_ok_w), .byte_i(rx_byte_w),
    .base_i(slot_base_i), .oe_o(miso_oe_o), .tx_sel_o(tx_sel_w),
    .slot_o(rx_slot_o), .done_o(slot_rx_done_o));

  // reply bit follows the receive bit slot, so it starts in step with the incoming byte
  always_ff @(posedge clk) begin
    if (!rst_n) miso_q <= 1'b1;
    else if (miso_oe_o && busy_w) miso_q <= wire_level(bidx_w, tx_bytes_w[tx_sel_w]);
    else miso_q <= 1'b1;
  end

  assign miso_o = miso_q;

  // R5: the enable moves only while the downstream line is idle or in a stop bit
  assert_oe_switch_in_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (miso_oe_o != $past(miso_oe_o)) |-> ($past(!busy_w) || $past(bidx_w) == 4'd9));
  // R7: a released line is never pulled low
  assert_quiet_when_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !miso_oe_o |-> miso_o);
endmodule

// File: tb/sabus_slot_node_test.sv
module sabus_slot_node_test;
  localparam int SLOT = 12;
  localparam int BT   = 16;
  localparam int TMO  = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0;
  logic [7:0] base = '0;
  logic [8*SLOT-1:0] tx_slot = '0;
  logic mosi = 1'b1;
  logic miso, miso_oe, done;
  logic [8*SLOT-1:0] rx_slot;

  int total = 0;
  int bad = 0;
  int done_seen = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sabus_slot_node #(.CLK_DIV(1), .BIT_TICKS(BT), .SLOT_BYTES(SLOT), .CNT_W(8),
                    .TIMEOUT_TICKS(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start), .slot_base_i(base),
    .tx_slot_i(tx_slot), .mosi_i(mosi), .miso_o(miso), .miso_oe_o(miso_oe),
    .rx_slot_o(rx_slot), .slot_rx_done_o(done));

  always @(posedge clk) if (done) done_seen++;

  // table: {slot base, rx seed, tx seed, extra bytes after window}
  localparam logic [31:0] CASES [4] = '{
    {8'd0, 8'h11, 8'h5A, 8'd2},
    {8'd3, 8'hA7, 8'h3C, 8'd1},
    {8'd1, 8'h00, 8'hFF, 8'd0},
    {8'd5, 8'h80, 8'h01, 8'd3}
  };

  function automatic logic [7:0] rx_pat(input logic [7:0] seed, input int i);
    return seed ^ 8'(i * 37 + 3);
  endfunction
  function automatic logic [7:0] tx_pat(input logic [7:0] seed, input int j);
    return 8'(seed + j * 29);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] got, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic pulse_frame();
    @(negedge clk) frame_start = 1'b1;
    @(negedge clk) frame_start = 1'b0;
  endtask

  // drives one byte; samples miso and the enable 10 clocks into each bit
  task automatic send_byte(input logic [7:0] d, output logic [9:0] line_bits,
                           output logic oe_and, output logic oe_or);
    logic [9:0] frame;
    frame = {1'b1, d, 1'b0};
    oe_and = 1'b1; oe_or = 1'b0;
    for (int b = 0; b < 10; b++) begin
      mosi = frame[b];
      repeat (10) @(negedge clk);
      line_bits[b] = miso;
      if (b >= 1 && b <= 8) begin
        oe_and &= miso_oe;
        oe_or  |= miso_oe;
      end
      repeat (BT - 10) @(negedge clk);
    end
  endtask

  // sends n bytes numbered from first; checks enable and reply of each
  task automatic send_run(input int first, input int n, input logic [7:0] rseed,
                          input logic [7:0] tseed, input int b0, input bit open);
    logic [9:0] lb;
    logic oa, oo;
    for (int i = first; i < first + n; i++) begin
      bit ins;
      ins = open && (i >= b0) && (i < b0 + SLOT);
      send_byte(rx_pat(rseed, i), lb, oa, oo);
      check(ins ? (oa === 1'b1) : (oo === 1'b0), "R5", $sformatf("enable byte %0d", i),
            {oa, oo}, {ins, ins});
      if (ins)
        check(lb === {1'b1, tx_pat(tseed, i - b0), 1'b0}, "R6",
              $sformatf("reply byte %0d", i), lb, {1'b1, tx_pat(tseed, i - b0), 1'b0});
      else
        check(lb === 10'h3FF, "R7", $sformatf("quiet line byte %0d", i), lb, 10'h3FF);
    end
  endtask

  function automatic logic [8*SLOT-1:0] exp_slot(input logic [7:0] rseed, input int b0);
    logic [8*SLOT-1:0] e;
    for (int j = 0; j < SLOT; j++) e[8*j +: 8] = rx_pat(rseed, b0 + j);
    return e;
  endfunction

  task automatic load_tx(input logic [7:0] tseed);
    for (int j = 0; j < SLOT; j++) tx_slot[8*j +: 8] = tx_pat(tseed, j);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int d0;
    logic [8*SLOT-1:0] keep;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(miso === 1'b1, "R1", "miso after reset", miso, 1);
    check(miso_oe === 1'b0, "R1", "enable after reset", miso_oe, 0);
    check(done === 1'b0, "R1", "done after reset", done, 0);
    check(rx_slot === '0, "R1", "slot after reset", rx_slot, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // table walk: R2 R3 R4 R5 R6 R7
    for (int c = 0; c < 4; c++) begin
      logic [7:0] b0, rs, ts, ex;
      {b0, rs, ts, ex} = CASES[c];
      base = b0; load_tx(ts);
      d0 = done_seen;
      pulse_frame();
      if (b0 == 0) check(miso_oe === 1'b1, "R10", "enable at frame start", miso_oe, 1);
      send_run(0, b0 + SLOT + ex, rs, ts, b0, 1'b1);
      check(rx_slot === exp_slot(rs, b0), "R2", $sformatf("window case %0d", c),
            rx_slot, exp_slot(rs, b0));
      check(done_seen - d0 == 1, "R4", $sformatf("done pulses case %0d", c),
            done_seen - d0, 1);
      repeat (TMO + 20) @(negedge clk);
    end

    // R8: a short low glitch is not a byte
    base = 8'd1; load_tx(8'h42); d0 = done_seen;
    pulse_frame();
    mosi = 1'b0; repeat (3) @(negedge clk); mosi = 1'b1;
    repeat (20) @(negedge clk);
    send_run(0, SLOT + 1, 8'h6B, 8'h42, 1, 1'b1);
    check(rx_slot === exp_slot(8'h6B, 1), "R8", "window after glitch",
          rx_slot, exp_slot(8'h6B, 1));
    check(done_seen - d0 == 1, "R8", "done after glitch", done_seen - d0, 1);
    repeat (TMO + 20) @(negedge clk);

    // R9: timeout closes the packet
    base = 8'd2; load_tx(8'h10); d0 = done_seen; keep = rx_slot;
    pulse_frame();
    send_run(0, 2, 8'hC3, 8'h10, 2, 1'b1);
    repeat (TMO + 40) @(negedge clk);
    check(miso_oe === 1'b0, "R9", "enable after timeout", miso_oe, 0);
    send_run(2, SLOT, 8'hC3, 8'h10, 2, 1'b0);
    check(rx_slot === keep, "R9", "window kept after timeout", rx_slot, keep);
    check(done_seen == d0, "R9", "no done after timeout", done_seen - d0, 0);

    // R9: frame start in the middle of a packet restarts the count
    base = 8'd1; load_tx(8'h77); d0 = done_seen;
    pulse_frame();
    send_run(0, 3, 8'h21, 8'h77, 1, 1'b1);
    pulse_frame();
    send_run(0, SLOT + 1, 8'h9E, 8'h77, 1, 1'b1);
    check(rx_slot === exp_slot(8'h9E, 1), "R9", "window after restart",
          rx_slot, exp_slot(8'h9E, 1));
    check(done_seen - d0 == 1, "R4", "single done across restart", done_seen - d0, 1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule